// File: doc/BRIEF.md
# Polled Byte Input Port

This block sits between a byte-wide input device and a processor that polls for input. The device offers a byte together with a valid strobe. The port copies the byte into its single holding register, raises a ready flag, and drives an accept line back to the device. The processor reads a status word to see whether a byte is waiting. When the flag is up, it reads the holding register, and that read lowers the flag.

The accept line is the only flow control the device sees. It stays high while the byte has not been collected, and also while the device still holds its valid strobe. It falls one edge after both conditions have cleared. After that the port is idle and takes the next byte. A valid strobe that arrives while accept is high is not captured, so the device must wait.

The processor side is a plain register bus. The read data is decoded from the address combinationally and is present in the same cycle. Writes are accepted on the bus but change nothing. Reset is synchronous and active high.

Top module: `polled_byte_port`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears the ready flag, clears the holding register to 0 and drives `dev_accept` low.
- R2: At a rising edge where `dev_valid` is 1 and `dev_accept` is 0, the port stores `dev_data` in the holding register and sets the ready flag. After that edge, `dev_accept` is 1.
- R3: `cpu_rdata` follows `cpu_addr` combinationally in the same cycle. Address 0 returns the status word, with the ready flag in bit 0 and all other bits 0. Address 1 returns the holding register. Any other address returns 0.
- R4: Reading the status word, or any address other than 1, leaves the ready flag unchanged.
- R5: A read strobe at address 1 while the ready flag is 1 returns the held byte and clears the flag at that edge.
- R6: `dev_accept` is 1 whenever the ready flag is 1. It falls at the first rising edge where the flag is already 0 and `dev_valid` is 0. While `dev_valid` stays high, it stays high.
- R7: While `dev_accept` is 1, `dev_valid` and `dev_data` are ignored, and the holding register keeps its byte.
- R8: A write strobe at any address changes neither the ready flag nor the holding register.
- R9: A read at address 1 while the flag is 0 returns the last stored byte and leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dev_valid | input | 1 | Device strobe: a byte is on `dev_data` |
| dev_data | input | DATA_W | Byte offered by the device |
| dev_accept | output | 1 | Byte taken; high until the byte is collected and the strobe has dropped |
| cpu_addr | input | ADDR_W | Register address (0 status, 1 holding register) |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe (no effect) |
| cpu_wdata | input | DATA_W | Write data (no effect) |
| cpu_rdata | output | DATA_W | Read data, decoded from `cpu_addr` |

## Verification
Read data depends only on the address and the stored state, so it is due in the same cycle as the address. A capture is visible one edge after the edge that sampled `dev_valid`. A collecting read lowers the flag at its own edge, and `dev_accept` falls one edge later at the earliest, or later if the strobe is still held. The bench changes inputs just after the falling edge and compares outputs 1 ns later, before the next rising edge. Each table row therefore sees the state left by the edge before it. The rows cover a strobe held across the collecting read, a strobe asserted while the flag is up, and writes to both registers.

// File: rtl/polled_byte_port.sv
module polled_byte_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_accept,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] HOLD_ADDR = ADDR_W'(1);

  logic              flag_q;
  logic              acc_q;
  logic [DATA_W-1:0] hold_q;

  wire take    = dev_valid & ~acc_q;
  wire collect = cpu_rd & (cpu_addr == HOLD_ADDR) & flag_q;
  wire release_acc = ~flag_q & ~dev_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      acc_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (take) begin
        hold_q <= dev_data;
        flag_q <= 1'b1;
        acc_q  <= 1'b1;
      end else begin
        if (collect) flag_q <= 1'b0;
        if (release_acc) acc_q <= 1'b0;
      end
    end
  end

  assign dev_accept = acc_q;

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == STAT_ADDR) cpu_rdata[0] = flag_q;
    else if (cpu_addr == HOLD_ADDR) cpu_rdata = hold_q;
  end
endmodule

module polled_byte_port_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              dev_valid,
  input logic              dev_accept,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              flag_q,
  input logic [DATA_W-1:0] hold_q
);
  wire rd_hold = cpu_rd && (cpu_addr == ADDR_W'(1));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!flag_q && !dev_accept && hold_q == '0));

  // R2
  capture_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !dev_accept) |=> (flag_q && dev_accept));

  // R4
  flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_hold) |=> flag_q);

  // R5
  collect_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && rd_hold) |=> !flag_q);

  // R6
  accept_covers_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> dev_accept);

  // R6
  accept_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !dev_valid) |=> !dev_accept);

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    dev_accept |=> $stable(hold_q));

  // R8
  write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && dev_accept && cpu_wdata != hold_q) |=> (hold_q != $past(cpu_wdata)));
endmodule

bind polled_byte_port polled_byte_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .dev_valid(dev_valid), .dev_accept(dev_accept),
  .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .flag_q(flag_q), .hold_q(hold_q)
);

// File: tb/polled_byte_port_test.sv
module polled_byte_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dev_valid = 1'b0;
  logic [7:0] dev_data = '0;
  logic       dev_accept;
  logic [1:0] cpu_addr = '0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  polled_byte_port #(.DATA_W(8), .ADDR_W(2)) uut (
    .clk(clk), .rst(rst), .dev_valid(dev_valid), .dev_data(dev_data),
    .dev_accept(dev_accept), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  typedef struct packed {
    logic       v;
    logic [7:0] d;
    logic       rd;
    logic       wr;
    logic [1:0] a;
    logic [7:0] wd;
    logic       ea;
    logic [7:0] er;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd3}, // R3 idle status
    '{1'b1, 8'hA5, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd2}, // R2 offer A5
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 4'd2}, // R2 flag up
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 4'd4}, // R4 status read kept flag
    '{1'b1, 8'h3C, 1'b0, 1'b1, 2'd1, 8'hFF, 1'b1, 8'hA5, 4'd7}, // R7 R8 strobe and write while full
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 8'hA5, 4'd5}, // R5 collect A5
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 4'd6}, // R6 flag low, accept still up
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd6}, // R6 accept released
    '{1'b1, 8'h5A, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd2}, // R2 offer 5A
    '{1'b1, 8'h5A, 1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 8'h5A, 4'd5}, // R5 collect with strobe held
    '{1'b1, 8'h77, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 4'd6}, // R6 held strobe keeps accept
    '{1'b1, 8'h77, 1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 8'h5A, 4'd9}, // R9 R7 empty read, 77 ignored
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 4'd9}, // R9 flag stayed low
    '{1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd6}, // R6 release after strobe drop
    '{1'b1, 8'hC3, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0, 8'h00, 4'd3}, // R3 unused address reads 0
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd2, 8'h00, 1'b1, 8'h00, 4'd4}, // R4 read of unused address
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 4'd4}, // R4 flag still up
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 8'h01, 4'd8}, // R8 write zero to status
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 4'd8}, // R8 flag survived write
    '{1'b0, 8'h00, 1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 8'hC3, 4'd5}, // R5 collect C3
    '{1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 4'd6}, // R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd6}  // R6
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cpu_addr = 2'd0; #1;
    check("R1", "accept after reset", {7'd0, dev_accept}, 8'h00);
    check("R1", "status after reset", cpu_rdata, 8'h00);
    cpu_addr = 2'd1; #1;
    check("R1", "data after reset", cpu_rdata, 8'h00);
    rst = 1'b0;
    @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dev_valid = VEC[i].v;  dev_data = VEC[i].d;
      cpu_rd = VEC[i].rd;    cpu_wr = VEC[i].wr;
      cpu_addr = VEC[i].a;   cpu_wdata = VEC[i].wd;
      #1;
      check($sformatf("R%0d row %0d", VEC[i].rq, i), "accept", {7'd0, dev_accept}, {7'd0, VEC[i].ea});
      check($sformatf("R%0d row %0d", VEC[i].rq, i), "rdata", cpu_rdata, VEC[i].er);
    end

    // R1 reset in the middle of a transfer
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = 2'd0;
    dev_valid = 1'b1; dev_data = 8'hE1;
    @(negedge clk);
    dev_valid = 1'b0; #1;
    check("R2", "status before reset", cpu_rdata, 8'h01);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    check("R1", "accept after mid reset", {7'd0, dev_accept}, 8'h00);
    check("R1", "status after mid reset", cpu_rdata, 8'h00);
    cpu_addr = 2'd1; #1;
    check("R1", "data after mid reset", cpu_rdata, 8'h00);
    @(negedge clk);
    finish_run();
  end
endmodule